// File: doc/BRIEF.md
# Seeded Arbiter PUF Delay Model

This block is a synthesizable, deterministic stand-in for an arbiter physically unclonable function. An N-bit challenge steers two racing signals through a chain of N switch stages. In each stage both paths either pass straight through or cross over. Every stage carries fixed per-path delays derived at elaboration time from a seed parameter. The block adds up the signed delay difference between the top and bottom paths along the steered route. An arbiter then turns the sign of the final difference into a one-bit response.

A given seed always produces the same challenge-to-response mapping, so simulations repeat exactly. Instances built with different seeds behave like different chips. The caller presents a challenge together with a one-cycle strobe. One clock later the block raises an output strobe in the cycle where the registered response holds that challenge's result.

Control is a two-state machine. `ARB_IDLE` means no response is being presented. `ARB_EMIT` means `valid_out` is high. The transitions are:
- `IDLE->EMIT` when `valid_in` is sampled high.
- `EMIT->EMIT` when another `valid_in` arrives in the very next cycle.
- `EMIT->IDLE` when `valid_in` is low.
- Reset forces `ARB_IDLE`.

Top module: `seeded_arbiter_puf`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `response` and `valid_out` are 0.
- R2: `valid_out` is high in exactly the clock cycle after a rising edge at which `valid_in` was sampled high, and low in every other cycle.
- R3: Strobes on consecutive cycles each give their own `valid_out` cycle, in order, with `response` in each cycle equal to the result for the matching challenge.
- R4: When `valid_in` is sampled low, `response` keeps its previous value in the next cycle.
- R5: Stage i (i = 0 to N-1) takes four signed delays from `base = SEED + i`. Draw j (j = 0..3) is `mix(base + (j+1)*64'h9E3779B97F4A7C15)`, using its low DW bits as a two's-complement value. The draws are, in order, top-straight, bottom-straight, top-crossed and bottom-crossed. `mix(z)` is: `z ^= z>>30; z *= 64'hBF58476D1CE4E5B9; z ^= z>>27; z *= 64'h94D049BB133111EB; z ^= z>>31` (all modulo 2^64).
- R6: Challenge bit i controls stage i, and stage 0 comes first in the race. The running difference D (top minus bottom) starts at 0. When the bit is 0 the paths go straight: D becomes D + (top-straight − bottom-straight). When the bit is 1 the paths cross: D becomes −D + (top-crossed − bottom-crossed).
- R7: `response` is 1 when the final D is strictly positive (top path first) and 0 when D is zero or negative.
- R8: The same challenge presented again gives the same response.
- R9: Instances with different SEED values each follow R5–R7 with their own seed, and so disagree on some challenges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_in | input | 1 | Strobe: challenge is sampled this edge |
| challenge | input | N | Stage select bits, bit i drives stage i |
| response | output | 1 | Registered race outcome |
| valid_out | output | 1 | Strobe marking the cycle response is fresh |

## Verification
A stage with a wrong delay draw or wrong routing does not corrupt every answer. It shows up only on challenges where the damaged term shifts the sign of the final difference, one cycle after the strobe. For this reason the bench compares many unrelated challenges, plus all-zero, all-one and walking-one patterns, against an independent model of R5–R7. A state machine stuck in `ARB_EMIT` or `ARB_IDLE` is visible on `valid_out` within one cycle of a strobe or of its absence.

// File: rtl/seeded_puf_pkg.sv
package seeded_puf_pkg;

    localparam logic [63:0] PUF_GOLDEN = 64'h9E3779B97F4A7C15;

    typedef enum logic [0:0] {
        ARB_IDLE = 1'b0,
        ARB_EMIT = 1'b1
    } arb_state_t;

    // 64-bit avalanche finalizer used to spread seed bits.
    function automatic logic [63:0] puf_mix64(input logic [63:0] x);
        logic [63:0] z;
        z = x;
        z = (z ^ (z >> 30)) * 64'hBF58476D1CE4E5B9;
        z = (z ^ (z >> 27)) * 64'h94D049BB133111EB;
        z = z ^ (z >> 31);
        return z;
    endfunction

    // Signed delay for draw index 'draw' of a stage with the given base.
    function automatic longint puf_delay(input logic [63:0] base,
                                         input int unsigned draw,
                                         input int unsigned dw);
        logic [63:0] z;
        z = puf_mix64(base + PUF_GOLDEN * 64'(draw + 1));
        return longint'(z << (64 - dw)) >>> (64 - dw);
    endfunction

endpackage

// File: rtl/puf_switch_stage.sv
module puf_switch_stage
    import seeded_puf_pkg::*;
#(
    parameter logic [63:0] SEED = 64'h9E3779B97F4A7C15,
    parameter int unsigned IDX  = 0,
    parameter int unsigned DW   = 16,
    parameter int unsigned AW   = 24
) (
    input  logic                 sel_cross,
    input  logic signed [AW-1:0] diff_in,
    output logic signed [AW-1:0] diff_out
);
    localparam logic [63:0] BASE = SEED + 64'(IDX);

    localparam longint TOP_STR = puf_delay(BASE, 0, DW);
    localparam longint BOT_STR = puf_delay(BASE, 1, DW);
    localparam longint TOP_CRS = puf_delay(BASE, 2, DW);
    localparam longint BOT_CRS = puf_delay(BASE, 3, DW);

    localparam longint STR_L = TOP_STR - BOT_STR;
    localparam longint CRS_L = TOP_CRS - BOT_CRS;
    localparam logic signed [AW-1:0] STR_DIFF = AW'(STR_L);
    localparam logic signed [AW-1:0] CRS_DIFF = AW'(CRS_L);

    // Crossing swaps which racer is on top, so the lead flips sign.
    always_comb begin
        if (sel_cross) diff_out = CRS_DIFF - diff_in;
        else           diff_out = diff_in + STR_DIFF;
    end
endmodule

// File: rtl/puf_race_chain.sv
module puf_race_chain #(
    parameter logic [63:0] SEED = 64'h9E3779B97F4A7C15,
    parameter int unsigned N    = 64,
    parameter int unsigned DW   = 16,
    parameter int unsigned AW   = 24
) (
    input  logic [N-1:0]         challenge,
    output logic signed [AW-1:0] final_diff
);
    logic signed [AW-1:0] lead [0:N];

    assign lead[0] = '0;

    for (genvar g = 0; g < N; g++) begin : g_stage
        puf_switch_stage #(
            .SEED (SEED),
            .IDX  (g),
            .DW   (DW),
            .AW   (AW)
        ) stage_i (
            .sel_cross (challenge[g]),
            .diff_in   (lead[g]),
            .diff_out  (lead[g+1])
        );
    end

    assign final_diff = lead[N];
endmodule

// File: rtl/puf_arbiter_ctrl.sv
module puf_arbiter_ctrl
    import seeded_puf_pkg::*;
#(
    parameter int unsigned AW = 24
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 valid_in,
    input  logic signed [AW-1:0] final_diff,
    output logic                 response,
    output logic                 valid_out
);
    arb_state_t state_q, state_d;
    logic       top_first;

    assign top_first = !final_diff[AW-1] && (final_diff != '0);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE: if (valid_in) state_d = ARB_EMIT;
            ARB_EMIT: state_d = valid_in ? ARB_EMIT : ARB_IDLE;
            default:  state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ARB_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        response <= 1'b0;
        else if (valid_in) response <= top_first;
    end

    assign valid_out = (state_q == ARB_EMIT);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |-> (!response && !valid_out));

    assert_strobe_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    assert_no_spurious_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    assert_hold_response_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(response));

    assert_arbiter_decision_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> (response == $past(top_first)));
endmodule

// File: rtl/seeded_arbiter_puf.sv
module seeded_arbiter_puf #(
    parameter int unsigned N       = 64,
    parameter int unsigned DW      = 16,
    parameter logic [63:0] SEED    = 64'h9E3779B97F4A7C15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_in,
    input  logic [N-1:0] challenge,
    output logic         response,
    output logic         valid_out
);
    localparam int unsigned AW = DW + $clog2(N) + 2;

    logic signed [AW-1:0] final_diff;

    puf_race_chain #(
        .SEED (SEED),
        .N    (N),
        .DW   (DW),
        .AW   (AW)
    ) chain_i (
        .challenge  (challenge),
        .final_diff (final_diff)
    );

    puf_arbiter_ctrl #(
        .AW (AW)
    ) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_in   (valid_in),
        .final_diff (final_diff),
        .response   (response),
        .valid_out  (valid_out)
    );
endmodule

// File: tb/seeded_arbiter_puf_tb.sv
module seeded_arbiter_puf_tb_top;
    localparam int N = 64;
    localparam logic [63:0] SEED_A = 64'h9E3779B97F4A7C15;
    localparam logic [63:0] SEED_B = 64'h0123456789ABCDEF;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         valid_in = 1'b0;
    logic [N-1:0] challenge = '0;
    logic         resp_a, vout_a, resp_b, vout_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    seeded_arbiter_puf #(.N(N), .DW(16), .SEED(SEED_A)) dut_i (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .challenge(challenge),
        .response(resp_a), .valid_out(vout_a));

    seeded_arbiter_puf #(.N(N), .DW(16), .SEED(SEED_B)) dut_b (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .challenge(challenge),
        .response(resp_b), .valid_out(vout_b));

    // Independent model from R5-R7.
    function automatic logic [63:0] m_mix(input logic [63:0] x);
        logic [63:0] z;
        z = x ^ (x >> 30);
        z = z * 64'hBF58476D1CE4E5B9;
        z = z ^ (z >> 27);
        z = z * 64'h94D049BB133111EB;
        return z ^ (z >> 31);
    endfunction

    function automatic longint m_draw(input logic [63:0] base, input int j);
        logic [63:0] z;
        logic [15:0] lo;
        z  = m_mix(base + 64'(j + 1) * 64'h9E3779B97F4A7C15);
        lo = z[15:0];
        return longint'($signed(lo));
    endfunction

    function automatic logic ref_resp(input logic [63:0] seed, input logic [N-1:0] ch);
        longint d = 0;
        for (int i = 0; i < N; i++) begin
            logic [63:0] b;
            b = seed + 64'(i);
            if (ch[i]) d = -d + (m_draw(b, 2) - m_draw(b, 3));
            else       d =  d + (m_draw(b, 0) - m_draw(b, 1));
        end
        return d > 0;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    // One strobe; checks strobe and response one cycle later (R2, R6, R7).
    task automatic apply_one(input string req, input logic [N-1:0] ch);
        @(negedge clk);
        valid_in  = 1'b1;
        challenge = ch;
        @(negedge clk);
        valid_in  = 1'b0;
        check({req, " valid_out R2"}, vout_a, 1'b1);
        check({req, " response"}, resp_a, ref_resp(SEED_A, ch));
        check({req, " seed B R9"}, resp_b, ref_resp(SEED_B, ch));
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        #1;
        check("R1 response in reset", resp_a, 1'b0);
        check("R1 valid_out in reset", vout_a, 1'b0);
        repeat (2) @(negedge clk);
        check("R1 valid_out held in reset", vout_a, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 no strobe after reset", vout_a, 1'b0);
    endtask

    task automatic t_patterns;
        apply_one("R6 all straight", '0);
        apply_one("R6 all crossed", '1);
        for (int i = 0; i < N; i += 7) apply_one("R6 walking one", N'(1) << i);
        apply_one("R7 alternating", {(N/2){2'b10}});
    endtask

    task automatic t_many;
        logic [63:0] s = 64'h1234_5678_9ABC_DEF0;
        int diffs = 0;
        for (int k = 0; k < 40; k++) begin
            s = m_mix(s + 64'd977);
            apply_one("R5 hashed challenge", s[N-1:0]);
            if (resp_a !== resp_b) diffs++;
        end
        n_tests++;
        if (diffs == 0) begin
            n_fail++;
            $display("FAIL R9: seeds disagree on %0d challenges, expected > 0", diffs);
        end
    endtask

    task automatic t_back_to_back;
        logic [N-1:0] ca = 64'hA5A5_0F0F_3C3C_9999;
        logic [N-1:0] cb = 64'h5A5A_F0F0_C3C3_6666;
        logic [N-1:0] cc = 64'h0000_FFFF_1234_8001;
        @(negedge clk); valid_in = 1'b1; challenge = ca;
        @(negedge clk); challenge = cb;
        check("R3 strobe A", vout_a, 1'b1);
        check("R3 response A", resp_a, ref_resp(SEED_A, ca));
        @(negedge clk); challenge = cc;
        check("R3 strobe B", vout_a, 1'b1);
        check("R3 response B", resp_a, ref_resp(SEED_A, cb));
        @(negedge clk); valid_in = 1'b0; challenge = ~cc;
        check("R3 strobe C", vout_a, 1'b1);
        check("R3 response C", resp_a, ref_resp(SEED_A, cc));
        @(negedge clk);
        check("R2 strobe drops", vout_a, 1'b0);
        check("R4 response held", resp_a, ref_resp(SEED_A, cc));
        @(negedge clk);
        check("R4 response still held", resp_a, ref_resp(SEED_A, cc));
    endtask

    task automatic t_repeat;
        logic [N-1:0] c = 64'hDEAD_BEEF_0BAD_F00D;
        logic first;
        apply_one("R8 first", c);
        first = resp_a;
        apply_one("R8 other", ~c);
        apply_one("R8 again", c);
        check("R8 repeat matches", resp_a, first);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_patterns();
        t_back_to_back();
        t_repeat();
        t_many();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule